// File: doc/BRIEF.md
# Interrupt Poll and Status Readback Unit

This unit is the processor-facing command and readback slice of an 8-level priority interrupt controller. The processor writes command bytes over a small clocked bus. The bus has an active-low chip select, active-low read and write strobes, one address bit and 8-bit data in each direction. The request and in-service arrays sit outside this unit. It reads their contents on `irr_i` and `isr_i`. It holds the mask register and the special-mask-mode flag itself.

A command byte written with address 0 and bits [4:3] = 2'b01 is the status/poll command. Bit 6 enables a change of special mask mode, and bit 5 gives the new value. Bit 2 arms a poll. Bit 1 enables a change of readback selection, and bit 0 picks the in-service register (1) or the request register (0). Once a poll is armed, the next read is treated as an interrupt acknowledge, whatever the address bit. That read returns a one-shot poll word and pulses `set_isr_o` and `irr_clr_o` for the winning level. The request array is told to hold its inputs through `freeze_o` from the poll write until that read ends. The poll sequencer has three states:
- **ST_IDLE**: normal status reads.
- **ST_ARMED**: a poll is pending.
- **ST_PREAD**: a poll read is in progress and the poll word is held.

It has four transitions:
- **T_ARM**, ST_IDLE to ST_ARMED, on a write with bit 2 set.
- **T_ACK**, ST_ARMED to ST_PREAD, on the first cycle of a read.
- **T_DONE**, ST_PREAD to ST_IDLE, when the read strobe or chip select rises.
- **T_REARM**, ST_PREAD to ST_ARMED, if a new poll write coincides with the end of the read.

Top module: `pic_poll_readback`

## Requirements
- R1: A status/poll command with bit 6 = 1 sets `smm_o` to bit 5 of that byte. With bit 6 = 0, `smm_o` keeps its value.
- R2: A status/poll command with bit 2 = 1 raises `freeze_o` from the following cycle. `freeze_o` stays high until the next read (cs_n = 0, rd_n = 0) ends, and is low after it.
- R3: On the first cycle of the poll read, if a level is eligible, `set_isr_o` and `irr_clr_o` carry the same one-hot bit for that level during exactly that cycle. Otherwise both stay zero.
- R4: The poll word has bit 7 = 1 when a level is eligible, bits 2:0 = that level's binary number, and bits 6:3 = 0. It stays steady for the whole poll read.
- R5: A status/poll command with bit 1 = 1 selects `isr_i` (bit 0 = 1) or `irr_i` (bit 0 = 0) for reads at address 0.
- R6: The selection persists over any number of reads, over commands with bit 1 = 0, and over a poll read. Normal status reads resume after a poll.
- R7: A write at address 1 loads the mask register. A read at address 1 returns the mask register when no poll is armed.
- R8: Priority is fixed, and level 0 is highest. A level is eligible if it is requested, unmasked and not in service. In normal mode, an in-service level also blocks every lower level. In special mask mode, only in-service levels themselves are excluded.
- R9: A poll read with no eligible level returns 8'h00 and pulses no strobe, so the request and in-service contents do not change.
- R10: After reset, `smm_o` = 0, `freeze_o` = 0, no poll is armed and reads at address 0 return `irr_i`.
- R11: Address-0 writes whose bits [4:3] are not 2'b01 change neither the mode, the selection, the mask nor the poll state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (status register, mask or poll word) |
| irr_i | input | 8 | Request register contents from the request array |
| isr_i | input | 8 | In-service register contents from the in-service array |
| freeze_o | output | 1 | Hold request sampling while a poll is pending or in progress |
| set_isr_o | output | 8 | One-hot pulse setting the winning in-service bit |
| irr_clr_o | output | 8 | One-hot pulse clearing the winning request bit |
| smm_o | output | 1 | Special mask mode flag |

## Verification
The assertions check the following on every cycle:
- the acknowledge strobes are one-hot, equal to each other, aimed at a requested level, and only issued while frozen;
- a poll write is followed by freeze;
- the mode flag moves only on an enabling command, and then to the written value;
- the poll word's unused bits are zero.

Some properties need a model of the register contents, so only the bench scenarios can show them:
- the choice of the winning level under masks, in-service blocking and special mask mode;
- the persistence of the readback selection across polls and ignored writes;
- the mask readback;
- the unchanged contents after an empty poll.

// File: rtl/pic_poll_pkg.sv
package pic_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PREAD = 2'd2
    } poll_st_t;

    typedef enum logic {
        SEL_IRR = 1'b0,
        SEL_ISR = 1'b1
    } rdsel_t;

    localparam int CMD_ESMM_BIT = 6;
    localparam int CMD_SMM_BIT  = 5;
    localparam int CMD_P_BIT    = 2;
    localparam int CMD_RR_BIT   = 1;
    localparam int CMD_RIS_BIT  = 0;
endpackage

// File: rtl/pic_bus_edge.sv
module pic_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_active,
    output logic rd_start,
    output logic wr_start
);
    logic rd_q, wr_q, wr_active;

    assign rd_active = !cs_n && !rd_n;
    assign wr_active = !cs_n && !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_active;
            wr_q <= wr_active;
        end
    end

    assign rd_start = rd_active && !rd_q;
    assign wr_start = wr_active && !wr_q;
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
    import pic_poll_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_LVL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             a0,
    input  logic [DW-1:0]    din,
    output logic [N_LVL-1:0] imr,
    output logic             smm,
    output rdsel_t           sel,
    output logic             poll_req
);
    logic cmd_hit;

    assign cmd_hit  = wr_start && !a0 && (din[4:3] == 2'b01);
    assign poll_req = cmd_hit && din[CMD_P_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr <= '0;
            smm <= 1'b0;
            sel <= SEL_IRR;
        end else begin
            if (wr_start && a0) begin
                imr <= din[N_LVL-1:0];
            end
            if (cmd_hit && din[CMD_ESMM_BIT]) begin
                smm <= din[CMD_SMM_BIT];
            end
            if (cmd_hit && din[CMD_RR_BIT]) begin
                sel <= din[CMD_RIS_BIT] ? SEL_ISR : SEL_IRR;
            end
        end
    end
endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
    parameter int N_LVL = 8,
    parameter int LVL_W = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] irr,
    input  logic [N_LVL-1:0] isr,
    input  logic [N_LVL-1:0] imr,
    input  logic             smm,
    output logic             found,
    output logic [LVL_W-1:0] lvl
);
    logic blocked;

    always_comb begin
        found   = 1'b0;
        lvl     = '0;
        blocked = 1'b0;
        for (int i = 0; i < N_LVL; i++) begin
            if (!found && !blocked) begin
                if (irr[i] && !imr[i] && !isr[i]) begin
                    found = 1'b1;
                    lvl   = i[LVL_W-1:0];
                end else if (isr[i] && !smm) begin
                    blocked = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pic_poll_readback.sv
module pic_poll_readback
    import pic_poll_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_LVL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             a0,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    input  logic [N_LVL-1:0] irr_i,
    input  logic [N_LVL-1:0] isr_i,
    output logic             freeze_o,
    output logic [N_LVL-1:0] set_isr_o,
    output logic [N_LVL-1:0] irr_clr_o,
    output logic             smm_o
);
    localparam int LVL_W = $clog2(N_LVL);

    poll_st_t         state, state_nxt;
    rdsel_t           sel;
    logic             rd_active, rd_start, wr_start, poll_req;
    logic [N_LVL-1:0] imr;
    logic             found;
    logic [LVL_W-1:0] lvl;
    logic [DW-1:0]    live_word, poll_hold;
    logic [N_LVL-1:0] win_vec;

    pic_bus_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rd_active (rd_active),
        .rd_start  (rd_start),
        .wr_start  (wr_start)
    );

    pic_cmd_regs #(.DW(DW), .N_LVL(N_LVL)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_start (wr_start),
        .a0       (a0),
        .din      (din),
        .imr      (imr),
        .smm      (smm_o),
        .sel      (sel),
        .poll_req (poll_req)
    );

    pic_prio_res #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_prio (
        .irr   (irr_i),
        .isr   (isr_i),
        .imr   (imr),
        .smm   (smm_o),
        .found (found),
        .lvl   (lvl)
    );

    always_comb begin
        live_word = '0;
        if (found) begin
            live_word[DW-1]      = 1'b1;
            live_word[LVL_W-1:0] = lvl;
        end
    end

    assign win_vec = found ? ({{(N_LVL-1){1'b0}}, 1'b1} << lvl) : '0;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (poll_req) state_nxt = ST_ARMED;            // T_ARM
            ST_ARMED: if (rd_start) state_nxt = ST_PREAD;            // T_ACK
            ST_PREAD: if (!rd_active) begin
                          state_nxt = poll_req ? ST_ARMED : ST_IDLE; // T_REARM / T_DONE
                      end
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // state register and held poll word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            poll_hold <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_ARMED && rd_start) begin
                poll_hold <= live_word;
            end
        end
    end

    // outputs
    always_comb begin
        freeze_o  = 1'b0;
        set_isr_o = '0;
        irr_clr_o = '0;
        unique case (state)
            ST_IDLE: begin
                if (a0) begin
                    dout = DW'(imr);
                end else begin
                    dout = (sel == SEL_ISR) ? DW'(isr_i) : DW'(irr_i);
                end
            end
            ST_ARMED: begin
                freeze_o = 1'b1;
                dout     = live_word;
                if (rd_start) begin
                    set_isr_o = win_vec;
                    irr_clr_o = win_vec;
                end
            end
            ST_PREAD: begin
                freeze_o = 1'b1;
                dout     = poll_hold;
            end
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/pic_poll_sva.sv
module pic_poll_sva #(
    parameter int N_LVL = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             a0,
    input logic [6:2]       cmd_d,
    input logic [6:3]       dout_mid,
    input logic [N_LVL-1:0] irr_i,
    input logic             freeze_o,
    input logic [N_LVL-1:0] set_isr_o,
    input logic [N_LVL-1:0] irr_clr_o,
    input logic             smm_o
);
    logic wq, ws, cmd_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wq <= 1'b0;
        else        wq <= !cs_n && !wr_n;
    end

    assign ws     = !cs_n && !wr_n && !wq;
    assign cmd_wr = ws && !a0 && (cmd_d[4:3] == 2'b01);

    AST_SMM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && cmd_d[6]) |=> $stable(smm_o)); // R1
    AST_SMM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_d[6]) |=> (smm_o == $past(cmd_d[5]))); // R1
    AST_POLL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_d[2]) |=> freeze_o); // R2
    AST_ACK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_isr_o) |-> freeze_o); // R2
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_isr_o)); // R3
    AST_ACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        set_isr_o == irr_clr_o); // R3
    AST_ACK_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_isr_o) |-> (|(set_isr_o & irr_i))); // R3
    AST_ACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_isr_o) |-> (!cs_n && !rd_n)); // R3
    AST_POLL_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && !cs_n && !rd_n) |-> (dout_mid == 4'b0000)); // R4
endmodule

bind pic_poll_readback pic_poll_sva #(.N_LVL(N_LVL)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .a0        (a0),
    .cmd_d     (din[6:2]),
    .dout_mid  (dout[6:3]),
    .irr_i     (irr_i),
    .freeze_o  (freeze_o),
    .set_isr_o (set_isr_o),
    .irr_clr_o (irr_clr_o),
    .smm_o     (smm_o)
);

// File: tb/test_pic_poll_readback.sv
`timescale 1ns/1ps
module test_pic_poll_readback;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout, set_isr_o, irr_clr_o;
    logic       freeze_o, smm_o;

    // bench model of the request / in-service arrays
    logic [7:0] irr_m = '0, isr_m = '0, req_add = '0, isr_drop = '0;

    // bench model of the unit's own state
    logic [7:0] imr_e = '0;
    logic       smm_e = 1'b0, sel_e = 1'b0, armed_e = 1'b0;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        irr_m <= (irr_m | req_add) & ~irr_clr_o;
        isr_m <= (isr_m | set_isr_o) & ~isr_drop;
    end

    pic_poll_readback i_pic_poll_readback (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .dout(dout), .irr_i(irr_m), .isr_i(isr_m),
        .freeze_o(freeze_o), .set_isr_o(set_isr_o), .irr_clr_o(irr_clr_o),
        .smm_o(smm_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // R8: fixed priority, level 0 first; returns {found, 4'b0, level}
    function automatic logic [7:0] exp_poll(input logic [7:0] irr, input logic [7:0] isr,
                                            input logic [7:0] imr, input logic smm);
        for (int i = 0; i < 8; i++) begin
            if (irr[i] && !imr[i] && !isr[i]) return {1'b1, 4'b0000, 3'(i)};
            if (isr[i] && !smm) return 8'h00;
        end
        return 8'h00;
    endfunction

    task automatic add_req(input logic [7:0] v);
        @(negedge clk) req_add = v;
        @(negedge clk) req_add = '0;
    endtask

    task automatic drop_isr(input logic [7:0] v);
        @(negedge clk) isr_drop = v;
        @(negedge clk) isr_drop = '0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk) begin cs_n = 1'b0; wr_n = 1'b0; a0 = a; din = d; end
        @(negedge clk);
        if (a) imr_e = d;
        else if (d[4:3] == 2'b01) begin
            if (d[6]) smm_e = d[5];
            if (d[1]) sel_e = d[0];
            if (d[2]) armed_e = 1'b1;
        end
        chk("R1 smm_o", {7'd0, smm_o}, {7'd0, smm_e});
        chk("R2/R11 freeze_o", {7'd0, freeze_o}, {7'd0, armed_e});
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic a, input string req);
        logic [7:0] exp, exp_irr, exp_isr, oh;
        exp_irr = irr_m; exp_isr = isr_m;
        if (armed_e) begin
            exp = exp_poll(irr_m, isr_m, imr_e, smm_e);
            if (exp[7]) begin
                oh = 8'h01 << exp[2:0];
                exp_irr = irr_m & ~oh;
                exp_isr = isr_m | oh;
            end
        end else begin
            exp = a ? imr_e : (sel_e ? isr_m : irr_m);
        end
        @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b0; a0 = a; end
        @(negedge clk);
        chk(req, dout, exp);
        @(negedge clk);
        chk({req, " held"}, dout, exp);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        if (armed_e) begin
            chk("R3/R9 request array", irr_m, exp_irr);
            chk("R3/R9 in-service array", isr_m, exp_isr);
            chk("R2 freeze released", {7'd0, freeze_o}, 8'h00);
            armed_e = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 smm_o", {7'd0, smm_o}, 8'h00);
        chk("R10 freeze_o", {7'd0, freeze_o}, 8'h00);
        rst_n = 1'b1;
        add_req(8'h5A);
        rd(1'b0, "R10 reads irr");
        // R7: mask write and readback
        wr(1'b1, 8'hC3);
        rd(1'b1, "R7 mask readback");
        // R9: empty poll (everything masked)
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h0C);
        rd(1'b0, "R9 empty poll word");
        rd(1'b0, "R6 irr after empty poll");
        // R3/R4/R8: poll with levels 3,4 eligible -> level 3
        wr(1'b1, 8'hC3);
        wr(1'b0, 8'h04 | 8'h08);
        rd(1'b1, "R4 poll word lvl3");
        // R5: select isr
        wr(1'b0, 8'h0B);
        rd(1'b0, "R5 isr select");
        rd(1'b0, "R6 isr persists");
        // R8 normal mode: isr lvl3 blocks lvl4
        wr(1'b0, 8'h0C);
        rd(1'b0, "R8 blocked by in-service");
        // R1/R8 special mask mode: lvl4 now eligible
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h0C);
        rd(1'b0, "R8 smm poll lvl4");
        rd(1'b0, "R6 isr after poll");
        wr(1'b0, 8'h48);
        // R11: non-command writes at address 0 ignored
        wr(1'b0, 8'h17);
        wr(1'b0, 8'h67);
        rd(1'b0, "R11 selection kept");
        rd(1'b1, "R11 mask kept");
        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 6);
            d = 8'($urandom);
            case (op)
                0: if (!armed_e) add_req(d);
                1: wr(1'b1, d & 8'h9F);
                2: wr(1'b0, {1'b0, d[6:5], 2'b01, ($urandom_range(0, 3) == 0), d[1:0]});
                3: rd(d[0], "R5/R6/R7 random read");
                4: drop_isr(8'h01 << d[2:0]);
                5: wr(1'b0, {d[7:5], 1'b1, d[3:0]});
                default: if (!armed_e) begin
                    wr(1'b0, 8'h0C);
                    rd(d[0], "R3/R4/R8 random poll");
                end
            endcase
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule